// File: doc/BRIEF.md
# Dual Accumulator Saturation Unit

This unit sits behind a guard-bit adder/subtracter and writes its result into one of two 40-bit accumulators held in 9.31 fractional form. The adder supplies its 40-bit sum, together with the carry out of the top bit, which is the true sign of the full-precision result. The unit applies one of three policies to that sum before storing it. It can clamp at the top of the 40-bit range. It can clamp at the edge of the 1.31 range. Or it can store the sum unchanged and let it wrap.

Each accumulator keeps two flags. The first is a guard-bit flag, which is recomputed on every write to that accumulator. The second is a sticky saturation flag, which stays set until software clears it. The unit also ORs each flag pair into a combined status bit. When saturation is off, it raises a one-cycle trap request the first time the wrap policy meets an overflow of the full 40-bit range.

All state is registered. A write that is accepted on a clock edge becomes visible at the outputs after that edge.

Top module: `acc_sat_unit`

## Requirements
- R1: After reset, both accumulators, all guard and saturation flags, both combined bits and the trap request are zero.
- R2: A write (`wr_en_i`=1) updates only the accumulator chosen by `tgt_i` (0 = A, 1 = B), along with its guard flag. The other accumulator and its guard flag keep their values. With `wr_en_i`=0 nothing changes except saturation flags that are being cleared.
- R3: With `sat_en_i`=1 and `narrow_i`=0, if `carry_i` differs from sum bit 39, the stored value is 0x7FFFFFFFFF when `carry_i`=0 and 0x8000000000 when `carry_i`=1. Otherwise the sum is stored unchanged.
- R4: With `sat_en_i`=1 and `narrow_i`=1, if `carry_i` and sum bits 39..31 are not all equal, the stored value is 0x007FFFFFFF when `carry_i`=0 and 0xFF80000000 when `carry_i`=1. Otherwise the sum is stored unchanged.
- R5: With `sat_en_i`=0, the sum is stored unchanged, even when the sign is lost.
- R6: On each write, the target's guard flag (`ovf_o` bit 0 = A, bit 1 = B) becomes 1 exactly when bits 39..31 of the stored value are not all equal. It is therefore never set by a write under the 1.31 policy.
- R7: A saturation event sets the target's flag (`sat_o` bit 0 = A, bit 1 = B). Under the 1.31 policy the event is a 1.31-range overflow. Under the other two policies it is a 40-bit overflow (`carry_i` differs from bit 39).
- R8: A saturation flag is sticky. Only `clr_sat_i` (one bit per accumulator, same bit order) clears it. A new event in the same cycle as a clear leaves the flag set.
- R9: `ovf_any_o` is the OR of both guard flags, and `sat_any_o` is the OR of both saturation flags.
- R10: `trap_o` is high for exactly the one cycle after a write that meets all of these conditions: `sat_en_i`=0, `trap_en_i`=1, a 40-bit overflow, and the target's saturation flag was 0 before that write. In every other cycle `trap_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write the adder result into the target accumulator |
| tgt_i | input | 1 | Target accumulator: 0 = A, 1 = B |
| sum_i | input | 40 | Raw adder sum |
| carry_i | input | 1 | Adder carry out of bit 39 (true sign) |
| sat_en_i | input | 1 | Saturation enable; 0 selects wrap |
| narrow_i | input | 1 | With saturation on: 1 = clamp to 1.31, 0 = clamp to 9.31 |
| trap_en_i | input | 1 | Allow trap requests in wrap mode |
| clr_sat_i | input | 2 | Clear saturation flag, bit 0 = A, bit 1 = B |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |
| ovf_o | output | 2 | Guard-bit flags, bit 0 = A |
| sat_o | output | 2 | Sticky saturation flags, bit 0 = A |
| ovf_any_o | output | 1 | OR of guard flags |
| sat_any_o | output | 1 | OR of saturation flags |
| trap_o | output | 1 | One-cycle trap request |

## Verification
The hardest situations to reach are at the exact edges of the clamp windows, and in the interaction of a trap with a flag that is already set or is being cleared in the same cycle. At full width, hitting every edge would take an impractical number of vectors. The bench therefore builds the unit with an 8-bit accumulator and a 4-bit narrow range. It then sweeps every sum and carry pair under every policy and for both targets. The sticky flags are carried across the sweep, so traps arise both with and without a prior flag. At regular points the bench clears the flags on their own, and at others it clears them in the same cycle as a write.

// File: rtl/acc_sat_pkg.sv
package acc_sat_pkg;
  typedef enum logic [1:0] {
    POL_WIDE   = 2'd0,
    POL_NARROW = 2'd1,
    POL_WRAP   = 2'd2
  } sat_pol_e;
endpackage

// File: rtl/acc_ovf_detect.sv
module acc_ovf_detect #(
  parameter int ACC_W      = 40,
  parameter int NARROW_MSB = 31
) (
  input  logic [ACC_W-1:0] sum_i,
  input  logic             carry_i,
  output logic             ovf_wide_o,
  output logic             ovf_narrow_o
);
  localparam int GW = ACC_W - NARROW_MSB;

  logic [GW:0] top_bits;

  always_comb begin
    top_bits     = {carry_i, sum_i[ACC_W-1:NARROW_MSB]};
    ovf_wide_o   = carry_i ^ sum_i[ACC_W-1];
    // true sign plus every bit from the narrow sign upward must agree
    ovf_narrow_o = !((&top_bits) || !(|top_bits));
  end
endmodule

// File: rtl/acc_clamp.sv
module acc_clamp
  import acc_sat_pkg::*;
#(
  parameter int ACC_W      = 40,
  parameter int NARROW_MSB = 31
) (
  input  sat_pol_e         pol_i,
  input  logic [ACC_W-1:0] sum_i,
  input  logic             carry_i,
  input  logic             ovf_wide_i,
  input  logic             ovf_narrow_i,
  output logic [ACC_W-1:0] res_o,
  output logic             event_o
);
  localparam int GW = ACC_W - NARROW_MSB;
  localparam logic [ACC_W-1:0] WIDE_POS = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] WIDE_NEG = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] NAR_POS  = {{GW{1'b0}}, {NARROW_MSB{1'b1}}};
  localparam logic [ACC_W-1:0] NAR_NEG  = {{GW{1'b1}}, {NARROW_MSB{1'b0}}};

  always_comb begin
    res_o   = sum_i;
    event_o = ovf_wide_i;
    unique case (pol_i)
      POL_WIDE: begin
        if (ovf_wide_i) res_o = carry_i ? WIDE_NEG : WIDE_POS;
      end
      POL_NARROW: begin
        event_o = ovf_narrow_i;
        if (ovf_narrow_i) res_o = carry_i ? NAR_NEG : NAR_POS;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_lane.sv
module acc_lane #(
  parameter int ACC_W      = 40,
  parameter int NARROW_MSB = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [ACC_W-1:0] res_i,
  input  logic             event_i,
  input  logic             clr_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             ovf_o,
  output logic             sat_o
);
  logic [ACC_W-1:NARROW_MSB] guard;
  logic guard_used;

  assign guard      = res_i[ACC_W-1:NARROW_MSB];
  assign guard_used = !((&guard) || !(|guard));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0;
      ovf_o <= 1'b0;
      sat_o <= 1'b0;
    end else begin
      if (we_i) begin
        acc_o <= res_i;
        ovf_o <= guard_used;
      end
      // set beats clear so a fresh event is never lost
      sat_o <= (sat_o && !clr_i) || (we_i && event_i);
    end
  end
endmodule

// File: rtl/acc_sat_unit.sv
module acc_sat_unit
  import acc_sat_pkg::*;
#(
  parameter int ACC_W      = 40,
  parameter int NARROW_MSB = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             tgt_i,
  input  logic [ACC_W-1:0] sum_i,
  input  logic             carry_i,
  input  logic             sat_en_i,
  input  logic             narrow_i,
  input  logic             trap_en_i,
  input  logic [1:0]       clr_sat_i,
  output logic [ACC_W-1:0] acc_a_o,
  output logic [ACC_W-1:0] acc_b_o,
  output logic [1:0]       ovf_o,
  output logic [1:0]       sat_o,
  output logic             ovf_any_o,
  output logic             sat_any_o,
  output logic             trap_o
);
  localparam int N_ACC = 2;

  sat_pol_e         pol;
  logic             ovf_wide, ovf_narrow, sat_event;
  logic [ACC_W-1:0] res;
  logic [ACC_W-1:0] acc_q [N_ACC];
  logic             trap_q;

  always_comb begin
    if (!sat_en_i)     pol = POL_WRAP;
    else if (narrow_i) pol = POL_NARROW;
    else               pol = POL_WIDE;
  end

  acc_ovf_detect #(.ACC_W(ACC_W), .NARROW_MSB(NARROW_MSB)) u_detect (
    .sum_i        (sum_i),
    .carry_i      (carry_i),
    .ovf_wide_o   (ovf_wide),
    .ovf_narrow_o (ovf_narrow)
  );

  acc_clamp #(.ACC_W(ACC_W), .NARROW_MSB(NARROW_MSB)) u_clamp (
    .pol_i        (pol),
    .sum_i        (sum_i),
    .carry_i      (carry_i),
    .ovf_wide_i   (ovf_wide),
    .ovf_narrow_i (ovf_narrow),
    .res_o        (res),
    .event_o      (sat_event)
  );

  for (genvar k = 0; k < N_ACC; k++) begin : g_lane
    acc_lane #(.ACC_W(ACC_W), .NARROW_MSB(NARROW_MSB)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en_i && (tgt_i == 1'(k))),
      .res_i   (res),
      .event_i (sat_event),
      .clr_i   (clr_sat_i[k]),
      .acc_o   (acc_q[k]),
      .ovf_o   (ovf_o[k]),
      .sat_o   (sat_o[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trap_q <= 1'b0;
    else         trap_q <= wr_en_i && (pol == POL_WRAP) && trap_en_i
                           && ovf_wide && !sat_o[tgt_i];
  end

  assign acc_a_o   = acc_q[0];
  assign acc_b_o   = acc_q[1];
  assign ovf_any_o = |ovf_o;
  assign sat_any_o = |sat_o;
  assign trap_o    = trap_q;
endmodule

// File: rtl/acc_sat_chk.sv
module acc_sat_chk #(
  parameter int ACC_W = 40
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             tgt_i,
  input logic             carry_i,
  input logic             sat_en_i,
  input logic             narrow_i,
  input logic             trap_en_i,
  input logic [1:0]       clr_sat_i,
  input logic [ACC_W-1:0] acc_a_o,
  input logic [ACC_W-1:0] acc_b_o,
  input logic [1:0]       ovf_o,
  input logic [1:0]       sat_o,
  input logic             sat_any_o,
  input logic             trap_o
);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(acc_a_o) && $stable(acc_b_o) && $stable(ovf_o)));

  p_wide_sign_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sat_en_i && !narrow_i && !tgt_i) |=> (acc_a_o[ACC_W-1] == $past(carry_i)));

  p_no_guard_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sat_en_i && narrow_i && tgt_i) |=> !ovf_o[1]);

  p_sticky_a_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_o[0] && !clr_sat_i[0]) |=> sat_o[0]);

  p_sticky_b_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_o[1] && !clr_sat_i[1]) |=> sat_o[1]);

  p_any_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sat_any_o) |-> $past(wr_en_i));

  p_trap_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> !trap_o);

  p_trap_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(wr_en_i && !sat_en_i && trap_en_i));
endmodule

bind acc_sat_unit acc_sat_chk #(.ACC_W(ACC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .tgt_i     (tgt_i),
  .carry_i   (carry_i),
  .sat_en_i  (sat_en_i),
  .narrow_i  (narrow_i),
  .trap_en_i (trap_en_i),
  .clr_sat_i (clr_sat_i),
  .acc_a_o   (acc_a_o),
  .acc_b_o   (acc_b_o),
  .ovf_o     (ovf_o),
  .sat_o     (sat_o),
  .sat_any_o (sat_any_o),
  .trap_o    (trap_o)
);

// File: tb/acc_sat_unit_tb_top.sv
module acc_sat_unit_tb_top;
  localparam int W  = 8;
  localparam int NM = 3;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en_i = 1'b0, tgt_i = 1'b0, carry_i = 1'b0;
  logic         sat_en_i = 1'b0, narrow_i = 1'b0, trap_en_i = 1'b0;
  logic [W-1:0] sum_i = '0;
  logic [1:0]   clr_sat_i = '0;
  logic [W-1:0] acc_a_o, acc_b_o;
  logic [1:0]   ovf_o, sat_o;
  logic         ovf_any_o, sat_any_o, trap_o;

  int n_chk = 0, n_bad = 0;
  int m_acc[2];
  bit m_ovf[2], m_sat[2];

  always #5 clk_i = ~clk_i;

  acc_sat_unit #(.ACC_W(W), .NARROW_MSB(NM)) dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int sval(input int u);
    return (u >= (1 << (W - 1))) ? u - (1 << W) : u;
  endfunction

  task automatic check_all(input string req, input bit exp_trap);
    check({req, " R2 acc_a"}, int'(acc_a_o), m_acc[0]);
    check({req, " R2 acc_b"}, int'(acc_b_o), m_acc[1]);
    check("R6 ovf", int'(ovf_o), {m_ovf[1], m_ovf[0]});
    check("R8 sat", int'(sat_o), {m_sat[1], m_sat[0]});
    check("R9 ovf_any", int'(ovf_any_o), int'(m_ovf[0] | m_ovf[1]));
    check("R9 sat_any", int'(sat_any_o), int'(m_sat[0] | m_sat[1]));
    check("R10 trap", int'(trap_o), int'(exp_trap));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    int idx;
    m_acc = '{0, 0};
    m_ovf = '{0, 0};
    m_sat = '{0, 0};
    repeat (2) @(negedge clk_i);
    check_all("R1 reset", 1'b0);
    rst_ni = 1'b1;
    idx = 0;
    for (int mode = 0; mode < 3; mode++) begin
      for (int t = 0; t < 2; t++) begin
        for (int c = 0; c < 2; c++) begin
          for (int s = 0; s < (1 << W); s++) begin
            int v, res, sres, limit;
            bit o39, o31, ev, tr;
            bit [1:0] clr;
            string req;
            v     = c ? s - (1 << W) : s;
            limit = 1 << NM;
            o39   = (c != ((s >> (W - 1)) & 1));
            o31   = (v > limit - 1) || (v < -limit);
            clr   = (((idx >> 4) & 3) == 3) ? 2'b11 : 2'b00;
            case (mode)
              0: begin res = o39 ? (c ? (1 << (W - 1)) : (1 << (W - 1)) - 1) : s; ev = o39; req = "R3"; end
              1: begin res = o31 ? (c ? (1 << W) - limit : limit - 1) : s; ev = o31; req = "R4"; end
              default: begin res = s; ev = o39; req = "R5"; end
            endcase
            tr = (mode == 2) && idx[0] && o39 && !m_sat[t];
            if (ev) req = {req, " R7"};
            @(negedge clk_i);
            wr_en_i = 1'b1; tgt_i = t[0]; carry_i = c[0]; sum_i = s[W-1:0];
            sat_en_i = (mode != 2); narrow_i = (mode == 1);
            trap_en_i = idx[0]; clr_sat_i = clr;
            @(negedge clk_i);
            wr_en_i = 1'b0; clr_sat_i = '0;
            sres = sval(res);
            m_acc[t] = res;
            m_ovf[t] = (sres > limit - 1) || (sres < -limit);
            for (int k = 0; k < 2; k++) m_sat[k] = m_sat[k] & !clr[k];
            m_sat[t] = m_sat[t] | ev;
            check_all(req, tr);
            if ((idx % 37) == 36) begin
              bit [1:0] cm;
              cm = 2'((idx / 37) % 3 + 1);
              clr_sat_i = cm;
              @(negedge clk_i);
              clr_sat_i = '0;
              for (int k = 0; k < 2; k++) if (cm[k]) m_sat[k] = 1'b0;
              check_all("R8 clear", 1'b0);
            end
            idx++;
          end
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule